// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block listens to the two wires of an I2C bus without ever driving them. It finds the points where a bus transaction opens and closes and keeps a flag that shows whether a transaction is in progress. Both wires are treated as asynchronous inputs. Each one is brought into a single fast system clock domain. Every edge check and every decision is then made on that clock, so no register in the block is ever clocked by a bus wire.

A transaction opens when the data wire falls while the clock wire stays high. It closes when the data wire rises while the clock wire stays high. On each of these events the block gives a one-cycle strobe, and it sets or clears the busy flag. A push-button reset clears the flag at any time. Changes on the data wire while the clock wire is low are ordinary data bits, and the block ignores them. A host-facing reporter or a byte decoder can sit behind the strobes and the flag.

Top module: `i2c_cond_monitor`

## Requirements
- R1: While `rstBtn` is high, and on the first cycle after it falls, `busBusy`, `startPulse` and `stopPulse` are 0. The synchronizers reset to the idle bus level of 1, so idle-high lines after reset produce no strobe.
- R2: A start condition sets `busBusy` to 1 together with a `startPulse`. A start condition is a synchronized data level going from 1 to 0 while the synchronized clock level is 1 in both the old and the new sample.
- R3: A stop condition gives a `stopPulse` and clears `busBusy` to 0. A stop condition is a synchronized data level going from 0 to 1 while the synchronized clock level is 1 in both samples.
- R4: Data-wire changes made while the clock wire is low produce no strobe and leave `busBusy` unchanged.
- R5: A start condition while `busBusy` is already 1 keeps `busBusy` at 1 and still emits `startPulse`.
- R6: Each strobe is exactly one clock cycle wide, and `startPulse` and `stopPulse` are never 1 in the same cycle.
- R7: A data-wire change that forms a condition is reported on the (SYNC_STAGES+1)-th rising clock edge after the change. With the default of 2 this is the third edge. The strobe is still 0 after the second edge.
- R8: `rstBtn` clears `busBusy` at any time. Coming out of reset with the clock wire low creates no false condition.
- R9: A stop condition while `busBusy` is 0 still emits `stopPulse`, and `busBusy` stays 0.
- R10: Toggling the clock wire while the data wire is steady produces no strobe.
- R11: If the clock wire rises in the same synchronized sample in which the data wire falls, that is not a start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rstBtn | input | 1 | Active-high synchronous reset from the push button |
| sclIn | input | 1 | Bus clock wire, asynchronous |
| sdaIn | input | 1 | Bus data wire, asynchronous |
| busBusy | output | 1 | 1 between a start condition and the next stop condition |
| startPulse | output | 1 | One-cycle strobe on a start condition |
| stopPulse | output | 1 | One-cycle strobe on a stop condition |

## Verification
The assertions assume the following about the inputs:
- `rstBtn` is synchronous to `clk`.
- Each bus wire holds a level for more than SYNC_STAGES+1 clock cycles, so the synchronizers see every change as one clean step.
- The bus is idle high when reset is released, or the clock wire is low at that point.

The bench changes the wires only on falling clock edges and holds every level for at least three cycles. Before it releases or applies a mid-run reset, it always parks the clock wire low or the whole bus high.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;

  // synchronized view of both wires: current sample and one sample back
  typedef struct packed {
    logic sclNow;
    logic sclOld;
    logic sdaNow;
    logic sdaOld;
  } lineView_t;

  // strobes from control into the datapath output registers
  typedef struct packed {
    logic pulseStart;
    logic pulseStop;
  } condStrobe_t;

endpackage

// File: rtl/i2c_line_stage.sv
module i2c_line_stage #(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic lineNow,
  output logic lineOld
);

  logic [SYNC_STAGES-1:0] chain;

  // synchronizer chain followed by one history register for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      chain   <= {SYNC_STAGES{IDLE_LEVEL}};
      lineOld <= IDLE_LEVEL;
    end else begin
      chain   <= {chain[SYNC_STAGES-2:0], rawIn};
      lineOld <= chain[SYNC_STAGES-1];
    end
  end

  assign lineNow = chain[SYNC_STAGES-1];

  AST_OLD_TRACKS_NOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lineOld == $past(lineNow))); // R7

endmodule

// File: rtl/i2c_mon_datapath.sv
module i2c_mon_datapath
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rawLines,
  input  condStrobe_t          strobe,
  output lineView_t            view,
  output logic                 startPulse,
  output logic                 stopPulse
);

  logic [NUM_LINES-1:0] nowBits;
  logic [NUM_LINES-1:0] oldBits;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      i2c_line_stage #(
        .SYNC_STAGES(SYNC_STAGES),
        .IDLE_LEVEL (1'b1)
      ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .rawIn  (rawLines[g]),
        .lineNow(nowBits[g]),
        .lineOld(oldBits[g])
      );
    end
  endgenerate

  always_comb begin
    view.sclNow = nowBits[LINE_SCL];
    view.sclOld = oldBits[LINE_SCL];
    view.sdaNow = nowBits[LINE_SDA];
    view.sdaOld = oldBits[LINE_SDA];
  end

  // registered one-cycle strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
    end else begin
      startPulse <= strobe.pulseStart;
      stopPulse  <= strobe.pulseStop;
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(startPulse && stopPulse)); // R6

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !startPulse); // R6

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stopPulse |=> !stopPulse); // R6

  AST_SCL_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(view.sclNow)) |-> (!startPulse && !stopPulse)); // R4

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lineView_t   view,
  output condStrobe_t strobe,
  output logic        busy
);

  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HELD = 1'b1
  } busState_t;

  busState_t state;
  busState_t stateNext;
  logic      sclSteady;

  always_comb begin
    sclSteady         = view.sclNow & view.sclOld;
    strobe.pulseStart = sclSteady & view.sdaOld & ~view.sdaNow;
    strobe.pulseStop  = sclSteady & ~view.sdaOld & view.sdaNow;
    stateNext         = state;
    if (strobe.pulseStart) begin
      stateNext = ST_HELD;
    end else if (strobe.pulseStop) begin
      stateNext = ST_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FREE;
    end else begin
      state <= stateNext;
    end
  end

  assign busy = (state == ST_HELD);

  AST_HELD_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    strobe.pulseStart |=> busy); // R5

  AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    strobe.pulseStop |=> !busy); // R3

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstBtn,
  input  logic sclIn,
  input  logic sdaIn,
  output logic busBusy,
  output logic startPulse,
  output logic stopPulse
);

  lineView_t            view;
  condStrobe_t          strobe;
  logic [NUM_LINES-1:0] rawLines;

  always_comb begin
    rawLines           = '0;
    rawLines[LINE_SCL] = sclIn;
    rawLines[LINE_SDA] = sdaIn;
  end

  i2c_mon_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rst       (rstBtn),
    .rawLines  (rawLines),
    .strobe    (strobe),
    .view      (view),
    .startPulse(startPulse),
    .stopPulse (stopPulse)
  );

  i2c_cond_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rstBtn),
    .view  (view),
    .strobe(strobe),
    .busy  (busBusy)
  );

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rstBtn)
    startPulse |-> busBusy); // R2

  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rstBtn)
    stopPulse |-> !busBusy); // R3

  AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (rstBtn)
    $rose(busBusy) |-> startPulse); // R2

  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rstBtn)
    $fell(busBusy) |-> (stopPulse || $past(rstBtn))); // R8

endmodule

// File: tb/sim_i2c_cond_monitor.sv
`timescale 1ns/1ps
module sim_i2c_cond_monitor;

  logic clk    = 1'b0;
  logic rstBtn = 1'b1;
  logic sclIn  = 1'b1;
  logic sdaIn  = 1'b1;
  logic busBusy;
  logic startPulse;
  logic stopPulse;

  int nChecks = 0;
  int nFails  = 0;
  int startSeen = 0;
  int stopSeen  = 0;
  int wideErr   = 0;
  int overlapErr = 0;
  logic lastStart = 1'b0;
  logic lastStop  = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_cond_monitor u0 (
    .clk       (clk),
    .rstBtn    (rstBtn),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .busBusy   (busBusy),
    .startPulse(startPulse),
    .stopPulse (stopPulse)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rstBtn) begin
      if (startPulse) startSeen++;
      if (stopPulse) stopSeen++;
      if (startPulse && lastStart) wideErr++;
      if (stopPulse && lastStop) wideErr++;
      if (startPulse && stopPulse) overlapErr++;
    end
    lastStart = startPulse;
    lastStop  = stopPulse;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLines(input logic s, input logic d);
    @(negedge clk);
    sclIn = s;
    sdaIn = d;
    idle(5);
  endtask

  task automatic tReset();
    idle(4);
    @(negedge clk);
    rstBtn = 1'b0;
    check("R1", busBusy, 0, "busy right after reset");
    check("R1", startPulse | stopPulse, 0, "strobes right after reset");
    idle(6);
    check("R1", startSeen + stopSeen, 0, "no condition from idle bus");
  endtask

  task automatic tStartLatency();
    @(negedge clk);
    sdaIn = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R7", startPulse, 0, "strobe after second edge");
    @(negedge clk);
    check("R7", startPulse, 1, "strobe after third edge");
    check("R2", busBusy, 1, "busy set by start");
    @(negedge clk);
    check("R6", startPulse, 0, "strobe one cycle wide");
    idle(3);
  endtask

  task automatic tDataBits();
    int s0 = startSeen;
    int p0 = stopSeen;
    logic [7:0] pattern = 8'hA5;
    for (int i = 7; i >= 0; i--) begin
      setLines(1'b0, sdaIn);
      setLines(1'b0, pattern[i]);
      setLines(1'b1, pattern[i]);
    end
    setLines(1'b0, sdaIn);
    check("R4", startSeen + stopSeen - s0 - p0, 0, "data bits under low clock");
    check("R4", busBusy, 1, "busy kept across data");
    s0 = startSeen;
    for (int i = 0; i < 4; i++) begin
      setLines(1'b1, sdaIn);
      setLines(1'b0, sdaIn);
    end
    check("R10", startSeen + stopSeen - s0 - p0, 0, "clock toggles with steady data");
  endtask

  task automatic tRepeatedStart();
    int s0 = startSeen;
    setLines(1'b0, 1'b1);
    setLines(1'b1, 1'b1);
    setLines(1'b1, 1'b0);
    check("R5", startSeen - s0, 1, "repeated start strobe count");
    check("R5", busBusy, 1, "busy held on repeated start");
  endtask

  task automatic tStop();
    int p0 = stopSeen;
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R3", stopSeen - p0, 1, "stop strobe count");
    check("R3", busBusy, 0, "busy cleared by stop");
  endtask

  task automatic tStopIdle();
    int p0 = stopSeen;
    setLines(1'b0, 1'b1);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R9", stopSeen - p0, 1, "stop strobe while idle");
    check("R9", busBusy, 0, "busy stays clear");
  endtask

  task automatic tCoincident();
    int s0 = startSeen;
    int p0 = stopSeen;
    setLines(1'b0, 1'b1);
    setLines(1'b1, 1'b0);
    check("R11", startSeen - s0, 0, "clock rise with data fall");
    check("R11", busBusy, 0, "busy not set");
    setLines(1'b0, 1'b0);
    setLines(1'b0, 1'b1);
    setLines(1'b1, 1'b1);
    check("R4", stopSeen - p0, 0, "data rise under low clock");
  endtask

  task automatic tResetMid();
    int s0;
    setLines(1'b1, 1'b0);
    check("R8", busBusy, 1, "busy before reset");
    setLines(1'b0, 1'b0);
    @(negedge clk);
    rstBtn = 1'b1;
    idle(2);
    rstBtn = 1'b0;
    s0 = startSeen + stopSeen;
    idle(5);
    check("R8", busBusy, 0, "busy cleared by button");
    setLines(1'b0, 1'b1);
    setLines(1'b1, 1'b1);
    check("R8", startSeen + stopSeen - s0, 0, "no false condition after reset");
    check("R8", busBusy, 0, "busy still clear");
  endtask

  initial begin
    tReset();
    tStartLatency();
    tDataBits();
    tRepeatedStart();
    tStop();
    tStopIdle();
    tCoincident();
    tResetMid();
    check("R6", wideErr, 0, "wide strobes");
    check("R6", overlapErr, 0, "overlapping strobes");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule